// File: doc/BRIEF.md
# Reorder Buffer with In-Order Retirement

This block is a circular instruction window that keeps instructions in the order they were issued, even though their results may arrive in any order. Each issue step claims the next slot. The index of that slot is returned as the rename tag, and execution units later use the tag to name the result. Results arrive on a broadcast result bus as a tag, a value and a branch outcome flag. They are parked in the slot and never written straight to architectural state.

Only the oldest slot may leave. It retires once its result is present, and it then presents its kind, destination register, value and tag to the register file or store path. A branch at the oldest position holds retirement until its outcome has been written back. If the branch was predicted correctly, it simply retires. If it was mispredicted, it retires together with a flush pulse that discards every younger slot in the same cycle. Issue resumes at the slot directly after the branch.

Top module: `rob_ring`

## Requirements
- R1: `alloc_tag_o` shows the slot the next accepted issue will take. Tags are handed out consecutively modulo DEPTH, starting at 0 after reset.
- R2: After reset, nothing retires, `flush_o` is low, `alloc_ready_o` is high and `alloc_tag_o` is 0.
- R3: A write-back whose tag names an occupied, incomplete slot stores its value and marks the slot complete. A slot never retires before its write-back.
- R4: Retirement follows issue order. Complete younger slots wait while the oldest slot is incomplete.
- R5: With DEPTH slots occupied, `alloc_ready_o` is low and a request on `alloc_valid_i` changes no state.
- R6: While the oldest slot is complete, one slot retires per cycle and shows its kind, destination, value and tag. An issue and a retirement in the same cycle both take effect, and the occupancy stays the same.
- R7: Kind encoding is 0 for ALU, 1 for store and 2 for branch. A branch at the oldest position blocks retirement until its write-back. A write-back with `wb_mispredict_i` = 0 lets the branch retire with `flush_o` low, and the slots behind it retire after it.
- R8: A branch written back with `wb_mispredict_i` = 1 retires with `flush_o` high. In that cycle `alloc_ready_o` is low. All younger slots are discarded, and the next tag is the branch tag plus one.
- R9: A write-back to a free or flushed slot is ignored. A slot later issued at that index still waits for its own write-back.
- R10: `wb_mispredict_i` on a write-back to a non-branch slot has no effect, and no flush follows.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| alloc_valid_i | input | 1 | Issue request |
| alloc_kind_i | input | 2 | Kind of issued instruction (0 ALU, 1 store, 2 branch) |
| alloc_dst_i | input | REG_W | Destination register of issued instruction |
| alloc_ready_o | output | 1 | A slot can be claimed this cycle |
| alloc_tag_o | output | TAG_W | Slot index given to the next issue |
| wb_valid_i | input | 1 | Result bus carries a result |
| wb_tag_i | input | TAG_W | Slot the result belongs to |
| wb_value_i | input | DATA_W | Result value |
| wb_mispredict_i | input | 1 | Branch outcome differs from prediction |
| commit_valid_o | output | 1 | Oldest slot retires this cycle |
| commit_kind_o | output | 2 | Kind of retiring slot |
| commit_dst_o | output | REG_W | Destination register of retiring slot |
| commit_value_o | output | DATA_W | Value of retiring slot |
| commit_tag_o | output | TAG_W | Index of retiring slot |
| flush_o | output | 1 | Retiring branch was mispredicted; younger slots discarded |

## Verification
Issue and retirement are the two functions that can fall in one cycle. The bench provokes this with a pipelined stream: in every cycle it issues a new slot, writes back the slot issued one cycle earlier, and so keeps the oldest slot complete while the ring wraps several times. It judges the overlap by requiring, in every cycle of the stream, `alloc_ready_o` high, the retiring tag two behind the issued tag, and the retired value equal to an arithmetic function of that tag. The flush cycle is the contrasting case: there retirement happens while issue is refused, and the bench checks that the next tag falls directly after the branch.

// File: rtl/rob_pkg.sv
package rob_pkg;
  typedef enum logic [1:0] {
    KIND_ALU    = 2'd0,
    KIND_STORE  = 2'd1,
    KIND_BRANCH = 2'd2
  } op_kind_e;
endpackage

// File: rtl/rob_ptrs.sv
module rob_ptrs #(
  parameter int DEPTH = 8,
  parameter int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             push_i,
  input  logic             pop_i,
  input  logic             flush_i,
  output logic [PTR_W-1:0] head_o,
  output logic [PTR_W-1:0] tail_o,
  output logic             full_o,
  output logic             empty_o
);
  localparam int CNT_W = $clog2(DEPTH + 1);

  logic [PTR_W-1:0] head_q, tail_q;
  logic [CNT_W-1:0] count_q;

  function automatic logic [PTR_W-1:0] wrap_inc(input logic [PTR_W-1:0] p);
    return (p == PTR_W'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      head_q  <= '0;
      tail_q  <= '0;
      count_q <= '0;
    end else if (flush_i) begin
      // oldest is the mispredicted branch: it leaves, everything behind it dies
      head_q  <= wrap_inc(head_q);
      tail_q  <= wrap_inc(head_q);
      count_q <= '0;
    end else begin
      if (pop_i)  head_q <= wrap_inc(head_q);
      if (push_i) tail_q <= wrap_inc(tail_q);
      count_q <= count_q + CNT_W'(push_i) - CNT_W'(pop_i);
    end
  end

  assign head_o  = head_q;
  assign tail_o  = tail_q;
  assign full_o  = (count_q == CNT_W'(DEPTH));
  assign empty_o = (count_q == '0);

  a_r5_count_bound: assert property (@(posedge clk_i) disable iff (!rst_ni)
    count_q <= CNT_W'(DEPTH));
  a_r5_no_push_when_full: assert property (@(posedge clk_i) disable iff (!rst_ni)
    full_o |-> !push_i);
endmodule

// File: rtl/rob_slot.sv
module rob_slot
  import rob_pkg::*;
#(
  parameter int REG_W  = 5,
  parameter int DATA_W = 32
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              set_i,
  input  op_kind_e          kind_i,
  input  logic [REG_W-1:0]  dst_i,
  input  logic              wb_hit_i,
  input  logic [DATA_W-1:0] wb_value_i,
  input  logic              wb_mis_i,
  input  logic              clear_i,
  output logic              valid_o,
  output logic              ready_o,
  output op_kind_e          kind_o,
  output logic [REG_W-1:0]  dst_o,
  output logic [DATA_W-1:0] value_o,
  output logic              mis_o
);
  logic              valid_q, ready_q, mis_q;
  op_kind_e          kind_q;
  logic [REG_W-1:0]  dst_q;
  logic [DATA_W-1:0] value_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      valid_q <= 1'b0;
      ready_q <= 1'b0;
      mis_q   <= 1'b0;
      kind_q  <= KIND_ALU;
      dst_q   <= '0;
      value_q <= '0;
    end else if (clear_i) begin
      valid_q <= 1'b0;
      ready_q <= 1'b0;
      mis_q   <= 1'b0;
    end else if (set_i) begin
      valid_q <= 1'b1;
      ready_q <= 1'b0;
      mis_q   <= 1'b0;
      kind_q  <= kind_i;
      dst_q   <= dst_i;
    end else if (wb_hit_i && valid_q && !ready_q) begin
      ready_q <= 1'b1;
      value_q <= wb_value_i;
      mis_q   <= wb_mis_i && (kind_q == KIND_BRANCH);
    end
  end

  assign valid_o = valid_q;
  assign ready_o = ready_q;
  assign kind_o  = kind_q;
  assign dst_o   = dst_q;
  assign value_o = value_q;
  assign mis_o   = mis_q;

  a_r3_ready_needs_wb: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(ready_q) |-> $past(wb_hit_i));
  a_r10_mis_only_branch: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mis_q |-> kind_q == KIND_BRANCH);
endmodule

// File: rtl/rob_ring.sv
module rob_ring
  import rob_pkg::*;
#(
  parameter int DEPTH  = 8,
  parameter int REG_W  = 5,
  parameter int DATA_W = 32,
  parameter int TAG_W  = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              alloc_valid_i,
  input  logic [1:0]        alloc_kind_i,
  input  logic [REG_W-1:0]  alloc_dst_i,
  output logic              alloc_ready_o,
  output logic [TAG_W-1:0]  alloc_tag_o,
  input  logic              wb_valid_i,
  input  logic [TAG_W-1:0]  wb_tag_i,
  input  logic [DATA_W-1:0] wb_value_i,
  input  logic              wb_mispredict_i,
  output logic              commit_valid_o,
  output logic [1:0]        commit_kind_o,
  output logic [REG_W-1:0]  commit_dst_o,
  output logic [DATA_W-1:0] commit_value_o,
  output logic [TAG_W-1:0]  commit_tag_o,
  output logic              flush_o
);
  logic [TAG_W-1:0]  head, tail;
  logic              full, empty, alloc_fire;
  logic [DEPTH-1:0]  s_valid, s_ready, s_mis;
  op_kind_e          s_kind  [DEPTH];
  logic [REG_W-1:0]  s_dst   [DEPTH];
  logic [DATA_W-1:0] s_value [DEPTH];

  assign commit_valid_o = s_valid[head] && s_ready[head];
  assign flush_o        = commit_valid_o && s_mis[head] && (s_kind[head] == KIND_BRANCH);
  assign alloc_ready_o  = !full && !flush_o;
  assign alloc_fire     = alloc_valid_i && alloc_ready_o;
  assign alloc_tag_o    = tail;
  assign commit_kind_o  = s_kind[head];
  assign commit_dst_o   = s_dst[head];
  assign commit_value_o = s_value[head];
  assign commit_tag_o   = head;

  rob_ptrs #(.DEPTH(DEPTH), .PTR_W(TAG_W)) u_ptrs (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .push_i  (alloc_fire),
    .pop_i   (commit_valid_o),
    .flush_i (flush_o),
    .head_o  (head),
    .tail_o  (tail),
    .full_o  (full),
    .empty_o (empty)
  );

  for (genvar i = 0; i < DEPTH; i++) begin : g_slot
    rob_slot #(.REG_W(REG_W), .DATA_W(DATA_W)) u_slot (
      .clk_i      (clk_i),
      .rst_ni     (rst_ni),
      .set_i      (alloc_fire && (tail == TAG_W'(i))),
      .kind_i     (op_kind_e'(alloc_kind_i)),
      .dst_i      (alloc_dst_i),
      .wb_hit_i   (wb_valid_i && (wb_tag_i == TAG_W'(i))),
      .wb_value_i (wb_value_i),
      .wb_mis_i   (wb_mispredict_i),
      .clear_i    (flush_o || (commit_valid_o && (head == TAG_W'(i)))),
      .valid_o    (s_valid[i]),
      .ready_o    (s_ready[i]),
      .kind_o     (s_kind[i]),
      .dst_o      (s_dst[i]),
      .value_o    (s_value[i]),
      .mis_o      (s_mis[i])
    );
  end

  a_r1_tag_step: assert property (@(posedge clk_i) disable iff (!rst_ni)
    alloc_fire |=> alloc_tag_o == (($past(alloc_tag_o) == TAG_W'(DEPTH - 1)) ?
                                   '0 : $past(alloc_tag_o) + 1'b1));
  a_r5_stall_holds_tag: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (alloc_valid_i && !alloc_ready_o && !commit_valid_o) |=> $stable(alloc_tag_o));
  a_r8_flush_empties: assert property (@(posedge clk_i) disable iff (!rst_ni)
    flush_o |=> !commit_valid_o);
  a_r4_empty_no_commit: assert property (@(posedge clk_i) disable iff (!rst_ni)
    empty |-> !commit_valid_o);
endmodule

// File: tb/rob_ring_test.sv
`timescale 1ns/1ps
module rob_ring_test;
  localparam int DEPTH = 8, REG_W = 5, DATA_W = 32, TAG_W = 3, N = 20;

  logic clk_i = 1'b0, rst_ni = 1'b0;
  logic alloc_valid_i = 0, alloc_ready_o, wb_valid_i = 0, wb_mispredict_i = 0;
  logic [1:0] alloc_kind_i = '0, commit_kind_o;
  logic [REG_W-1:0] alloc_dst_i = '0, commit_dst_o;
  logic [TAG_W-1:0] alloc_tag_o, wb_tag_i = '0, commit_tag_o;
  logic [DATA_W-1:0] wb_value_i = '0, commit_value_o;
  logic commit_valid_o, flush_o;
  int checks = 0, errors = 0;
  bit done = 0;

  always #2 clk_i = ~clk_i;

  rob_ring #(.DEPTH(DEPTH), .REG_W(REG_W), .DATA_W(DATA_W), .TAG_W(TAG_W)) uut (.*);

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic step();
    @(posedge clk_i); #1;
    alloc_valid_i = 0; wb_valid_i = 0; wb_mispredict_i = 0;
  endtask

  task automatic alloc(input logic [1:0] k, input logic [REG_W-1:0] d);
    alloc_valid_i = 1; alloc_kind_i = k; alloc_dst_i = d;
  endtask

  task automatic wb(input logic [TAG_W-1:0] t, input logic [DATA_W-1:0] v, input logic m);
    wb_valid_i = 1; wb_tag_i = t; wb_value_i = v; wb_mispredict_i = m;
  endtask

  function automatic logic [31:0] f(input int n);
    return 32'(n * 3 + 7);
  endfunction

  initial begin
    repeat (3) @(posedge clk_i);
    #1; rst_ni = 1;
    chk("R2 commit", commit_valid_o, 0);
    chk("R2 flush", flush_o, 0);
    chk("R2 ready", alloc_ready_o, 1);
    chk("R2 tag", alloc_tag_o, 0);
    wb(3, 32'hbad, 0);                       // R9: write-back to a free slot
    for (int i = 0; i < DEPTH; i++) begin
      step();
      chk("R1 tag", alloc_tag_o, i);
      alloc(0, REG_W'(i));
    end
    step();
    chk("R5 full", alloc_ready_o, 0);
    chk("R9 no early commit", commit_valid_o, 0);
    alloc(1, 31);                            // R5: ignored while full
    for (int t = DEPTH - 1; t >= 1; t--) begin
      step();
      chk("R4 head blocks", commit_valid_o, 0);
      chk("R5 tag held", alloc_tag_o, 0);
      wb(TAG_W'(t), 100 + t, 0);
    end
    step();
    chk("R4 head blocks", commit_valid_o, 0);
    wb(0, 100, 0);
    for (int k = 0; k < DEPTH; k++) begin
      step();
      chk("R4 order valid", commit_valid_o, 1);
      chk("R4 order tag", commit_tag_o, k);
      chk("R6 value", commit_value_o, 100 + k);
      chk("R5 dst kept", commit_dst_o, k);
      chk("R5 kind kept", commit_kind_o, 0);
    end
    step();
    chk("R6 drained", commit_valid_o, 0);
    chk("R1 wrap", alloc_tag_o, 0);

    // R6 overlap of issue and retirement, R10 mispredict on ALU ignored
    for (int p = 0; p < N + 2; p++) begin
      if (p > 0) step();
      chk("R6 ready", alloc_ready_o, 1);
      chk("R10 flush", flush_o, 0);
      if (p >= 2) begin
        chk("R6 valid", commit_valid_o, 1);
        chk("R6 tag", commit_tag_o, (p - 2) % DEPTH);
        chk("R6 value", commit_value_o, f(p - 2));
        chk("R6 dst", commit_dst_o, (p - 2) % 32);
      end
      if (p < N) begin
        chk("R1 stream tag", alloc_tag_o, p % DEPTH);
        alloc(0, REG_W'(p % 32));
      end
      if (p >= 1 && p <= N) wb(TAG_W'((p - 1) % DEPTH), f(p - 1), 1);
    end
    step();
    chk("R6 drained", commit_valid_o, 0);
    chk("R1 tag", alloc_tag_o, 4);

    // R7 branch resolved correctly
    alloc(0, 1);
    step(); alloc(2, 0);
    step(); alloc(0, 2);
    step(); alloc(1, 3);
    step(); wb(6, 32'h66, 0);
    step(); wb(7, 32'h77, 0);
    step(); wb(4, 32'h44, 0);
    step();
    chk("R7 older first", commit_tag_o, 4);
    chk("R7 older value", commit_value_o, 32'h44);
    for (int i = 0; i < 3; i++) begin
      step();
      chk("R7 branch blocks", commit_valid_o, 0);
    end
    wb(5, 0, 0);
    step();
    chk("R7 branch retires", commit_valid_o, 1);
    chk("R7 branch tag", commit_tag_o, 5);
    chk("R7 kind", commit_kind_o, 2);
    chk("R7 no flush", flush_o, 0);
    step();
    chk("R7 after branch", commit_tag_o, 6);
    chk("R7 value", commit_value_o, 32'h66);
    step();
    chk("R7 store tag", commit_tag_o, 7);
    chk("R7 store kind", commit_kind_o, 1);
    chk("R7 store dst", commit_dst_o, 3);
    step();
    chk("R7 drained", commit_valid_o, 0);

    // R8 mispredicted branch
    chk("R1 tag", alloc_tag_o, 0);
    alloc(2, 0);
    step(); alloc(0, 6);
    step(); alloc(0, 7);
    step(); wb(1, 1, 0);
    step(); wb(2, 2, 0);
    step(); wb(0, 0, 1);
    step();
    chk("R8 commit", commit_valid_o, 1);
    chk("R8 tag", commit_tag_o, 0);
    chk("R8 flush", flush_o, 1);
    chk("R8 issue blocked", alloc_ready_o, 0);
    alloc(0, 9);
    step();
    chk("R8 younger gone", commit_valid_o, 0);
    chk("R8 flush low", flush_o, 0);
    chk("R8 ready", alloc_ready_o, 1);
    chk("R8 next tag", alloc_tag_o, 1);
    wb(1, 32'hdead, 0);                       // R9: flushed slot
    step();
    chk("R9 ignored", commit_valid_o, 0);
    alloc(0, 5);
    for (int i = 0; i < 2; i++) begin
      step();
      chk("R9 waits own wb", commit_valid_o, 0);
    end
    wb(1, 32'h55, 0);
    step();
    chk("R9 commit", commit_valid_o, 1);
    chk("R9 value", commit_value_o, 32'h55);
    chk("R9 dst", commit_dst_o, 5);
    step();
    chk("R9 drained", commit_valid_o, 0);

    if (!done) begin
      done = 1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    repeat (20000) @(posedge clk_i);
    if (!done) begin
      done = 1;
      checks++; errors++;
      $display("FAIL watchdog: actual=hung expected=finished");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule